// File: doc/BRIEF.md
# Linked-List Command Loader for a DMA Channel

This block is the sequencing half of one DMA channel. Software places a chain of eight-word command descriptors in memory, writes the address of the first one into the channel's node-pointer register, and then sets the list bit in the channel's control word. The loader reads the eight words one at a time over a simple request/grant/read-data port. Each word goes into the matching slot of the channel's register window. The loader then hands the command to an external data mover through a start/done handshake and follows the node pointer to the next descriptor.

A zero pointer ends the chain. A pointer that leads back to an earlier node makes the channel cycle until software cancels it. The loader emits one event strobe when the first descriptor of a list has been loaded and one more for each command the mover finishes; a completion counter elsewhere consumes these strobes. While a command is being moved, a readable counter shows the bytes still to go, minus one.

Top module: `lldma_loader`

## Requirements
- R1: The channel's window starts at byte address CHAN_IDX×0x40 (0x80 by default). Word slots 0x00..0x18 hold general config, read-port config, read address, write address, size (only bits 23:0 read back), next-node pointer and commands-done. Slot 0x1C is control/status and slot 0x30 is the remaining-byte counter. Writes and reads outside the window have no effect and read as 0.
- R2: A write to 0x1C with bit 4 = 1 and bit 20 = 0 while the channel is idle starts the list. Control bit 4 then reads 1 until the channel returns to idle, and control bit 0 reads 1 while a command is with the mover. A write with both bits set starts nothing.
- R3: A descriptor is fetched as eight word reads at node, node+4, …, node+28. Each request is held with a steady address until it is granted, and no new request is made until the read data of the previous one has returned. Words 0..6 land in window slots 0x00..0x18.
- R4: After the eighth word arrives, mv_start pulses for one cycle with mv_rd_addr = word 2, mv_wr_addr = word 3 and mv_size = word 4 bits 23:0.
- R5: evt pulses once when the first descriptor of a list has been loaded and once for every mv_done of a running command, so a list of N commands gives N+1 pulses.
- R6: After mv_done, a nonzero next-node pointer leads directly to fetching that node, with no write to memory. A zero pointer returns the channel to idle, clears control bit 4 and stops all requests.
- R7: A pointer that leads back to an earlier node makes the chain repeat without end, issuing the commands in chain order.
- R8: A write to 0x1C with bit 20 = 1 while the channel is active returns it to idle. It pulses mv_abort if a command is with the mover, and there are no further requests, starts or events. Cancel while idle has no effect.
- R9: Slot 0x30 holds the bytes remaining minus one, modulo 2^24. It is all ones after reset and whenever the channel is idle, it is loaded with the size field at mv_start, and it drops by mv_bytes on each mv_beat.
- R10: While control bit 4 reads 1, software writes to slots 0x00..0x18 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | MEM_AW | Byte address of the requested word |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | One-cycle command start to the mover |
| mv_abort | output | 1 | One-cycle abort of the running command |
| mv_rd_addr | output | 32 | Source address of the command |
| mv_wr_addr | output | 32 | Destination address of the command |
| mv_size | output | SIZE_W | Byte count minus one of the command |
| mv_beat | input | 1 | Mover moved mv_bytes this cycle |
| mv_bytes | input | BYTE_W | Bytes moved in this beat |
| mv_done | input | 1 | Mover finished the command |
| evt | output | 1 | Completion event strobe |

## Verification
The bench counts events across a single node, a three-node chain and a two-node loop. A loader that fails to report the list load, or that counts it twice, gives a total that is off by one from N+1. It reads the remaining counter while the mover is frozen before and after two beats. An off-by-one in the minus-one encoding, or a counter that does not return to all ones at idle, shows up in those reads. It cancels a looping chain while a command is with the mover. A design that kept fetching, missed the abort pulse or left the list bit set would show up in the fetch, start and control-word readings taken afterwards. It also checks that writes to the window of a different channel, cancels while idle and config writes made during a run all leave the channel unchanged.

// File: rtl/lldma_pkg.sv
// Shared constants and types of the linked-list command loader.
// Assumes a fixed eight-word descriptor whose word order matches the
// channel's register window slots.
package lldma_pkg;
    localparam int DESC_WORDS  = 8;
    localparam int IDX_W       = $clog2(DESC_WORDS);
    localparam int WORD_RADDR  = 2;
    localparam int WORD_WADDR  = 3;
    localparam int WORD_SIZE   = 4;
    localparam int WORD_NODE   = 5;
    localparam int WORD_CTRL   = 7;
    localparam int WORD_REMAIN = 12;
    localparam int BIT_RUN     = 0;
    localparam int BIT_LIST    = 4;
    localparam int BIT_CANCEL  = 20;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_WAIT, S_ISSUE, S_RUN, S_DRAIN
    } seq_state_e;
endpackage

// File: rtl/lldma_regs.sv
// Channel register window: seven descriptor word slots, a composed
// control/status word and the remaining-byte counter view.
// Assumes the loader's fills take priority over software writes, and that
// software writes to the slots are dropped while the channel is busy.
module lldma_regs
    import lldma_pkg::*;
#(
    parameter int REG_AW   = 12,
    parameter int CHAN_IDX = 2,
    parameter int SIZE_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              listing,
    input  logic              moving,
    input  logic [SIZE_W-1:0] remain,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [31:0]       fill_data,
    output logic              start_req,
    output logic              cancel_req,
    output logic [31:0]       cfg_rd_addr,
    output logic [31:0]       cfg_wr_addr,
    output logic [SIZE_W-1:0] cfg_size,
    output logic [31:0]       cfg_node
);
    localparam int CH_W = REG_AW - 6;
    localparam int SLOTS = DESC_WORDS - 1;

    logic        sel;
    logic [3:0]  woff;
    logic        ctrl_wr;
    logic [31:0] word_q [SLOTS];

    assign sel     = (reg_addr[REG_AW-1:6] == CH_W'(CHAN_IDX));
    assign woff    = reg_addr[5:2];
    assign ctrl_wr = reg_we && sel && (woff == 4'(WORD_CTRL));

    // Control-word writes become start and cancel requests.
    assign start_req  = ctrl_wr && reg_wdata[BIT_LIST] && !reg_wdata[BIT_CANCEL];
    assign cancel_req = ctrl_wr && reg_wdata[BIT_CANCEL];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            // Slot update: descriptor fill first, idle software write second.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q[g] <= '0;
                else if (fill_we && fill_idx == IDX_W'(g))
                    word_q[g] <= fill_data;
                else if (reg_we && sel && !busy && woff == 4'(g))
                    word_q[g] <= reg_wdata;
            end
        end
    endgenerate

    assign cfg_rd_addr = word_q[WORD_RADDR];
    assign cfg_wr_addr = word_q[WORD_WADDR];
    assign cfg_size    = word_q[WORD_SIZE][SIZE_W-1:0];
    assign cfg_node    = word_q[WORD_NODE];

    // Read mux over the window; anything unmapped reads zero.
    always_comb begin
        reg_rdata = '0;
        if (sel) begin
            if (woff == 4'(WORD_SIZE))
                reg_rdata = 32'(cfg_size);
            else if (woff < 4'(WORD_CTRL))
                reg_rdata = word_q[woff[IDX_W-1:0]];
            else if (woff == 4'(WORD_CTRL)) begin
                reg_rdata[BIT_LIST] = listing;
                reg_rdata[BIT_RUN]  = moving;
            end else if (woff == 4'(WORD_REMAIN))
                reg_rdata = 32'(remain);
        end
    end
endmodule

// File: rtl/lldma_remain.sv
// Remaining-byte counter, kept as bytes left minus one so that a finished
// command wraps to all ones. Assumes clear wins over load and beat.
module lldma_remain #(
    parameter int SIZE_W = 24,
    parameter int BYTE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [SIZE_W-1:0] load_val,
    input  logic              beat,
    input  logic [BYTE_W-1:0] bytes,
    output logic [SIZE_W-1:0] remain
);
    // Counter update: idle forces all ones, start loads, beats subtract.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '1;
        else if (clear)
            remain <= '1;
        else if (load)
            remain <= load_val;
        else if (beat)
            remain <= remain - SIZE_W'(bytes);
    end
endmodule

// File: rtl/lldma_seq.sv
// Descriptor sequencer: fetches eight words per node one request at a
// time, issues the command, waits for the mover and follows the chain.
// Assumes the memory returns exactly one read-data beat per grant; a
// cancel with a read outstanding waits for that beat before idling.
module lldma_seq
    import lldma_pkg::*;
#(
    parameter int MEM_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              cancel_req,
    input  logic [MEM_AW-1:0] node_ptr,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              fill_we,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [31:0]       fill_data,
    output logic              mv_start,
    output logic              mv_abort,
    input  logic              mv_done,
    output logic              evt,
    output logic              busy,
    output logic              listing,
    output logic              moving,
    output logic              go_idle
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DESC_WORDS - 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [MEM_AW-1:0] cur_node;
    logic              first_q;
    logic              cancel;
    logic              chain_end;

    assign cancel    = cancel_req && (state != S_IDLE);
    assign chain_end = (state == S_RUN) && mv_done && (node_ptr == '0);

    assign mem_req   = (state == S_FETCH);
    assign mem_addr  = cur_node + MEM_AW'({idx, 2'b00});
    assign fill_we   = (state == S_WAIT) && mem_rvalid && !cancel;
    assign fill_idx  = idx;
    assign fill_data = mem_rdata;
    assign mv_start  = (state == S_ISSUE) && !cancel;
    assign mv_abort  = (state == S_RUN) && cancel;
    assign evt       = ((state == S_ISSUE) && first_q && !cancel) ||
                       ((state == S_RUN) && mv_done && !cancel);
    assign busy      = (state != S_IDLE);
    assign listing   = busy && (state != S_DRAIN);
    assign moving    = (state == S_RUN);
    assign go_idle   = cancel || chain_end;

    // Sequencer state, word index, node cursor and first-load flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            idx      <= '0;
            cur_node <= '0;
            first_q  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start_req && !cancel_req) begin
                    state    <= S_FETCH;
                    idx      <= '0;
                    cur_node <= node_ptr;
                    first_q  <= 1'b1;
                end
                S_FETCH: if (cancel)
                    state <= mem_gnt ? S_DRAIN : S_IDLE;
                else if (mem_gnt)
                    state <= S_WAIT;
                S_WAIT: if (cancel)
                    state <= mem_rvalid ? S_IDLE : S_DRAIN;
                else if (mem_rvalid) begin
                    if (idx == LAST)
                        state <= S_ISSUE;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                S_ISSUE: if (cancel)
                    state <= S_IDLE;
                else begin
                    state   <= S_RUN;
                    first_q <= 1'b0;
                end
                S_RUN: if (cancel || chain_end)
                    state <= S_IDLE;
                else if (mv_done) begin
                    cur_node <= node_ptr;
                    idx      <= '0;
                    state    <= S_FETCH;
                end
                S_DRAIN: if (mem_rvalid)
                    state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lldma_loader.sv
// Top of the linked-list command loader for one DMA channel: register
// window, descriptor sequencer and remaining-byte counter.
// Assumes one mover per channel and a word-wide descriptor memory port.
module lldma_loader #(
    parameter int MEM_AW    = 32,
    parameter int REG_AW    = 12,
    parameter int CHAN_IDX  = 2,
    parameter int SIZE_W    = 24,
    parameter int BUS_BYTES = 4,
    localparam int BYTE_W   = $clog2(BUS_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              mv_start,
    output logic              mv_abort,
    output logic [31:0]       mv_rd_addr,
    output logic [31:0]       mv_wr_addr,
    output logic [SIZE_W-1:0] mv_size,
    input  logic              mv_beat,
    input  logic [BYTE_W-1:0] mv_bytes,
    input  logic              mv_done,
    output logic              evt
);
    logic                     busy_w, listing_w, moving_w, go_idle_w;
    logic                     start_w, cancel_w;
    logic                     fill_we_w;
    logic [lldma_pkg::IDX_W-1:0] fill_idx_w;
    logic [31:0]              fill_data_w;
    logic [31:0]              node_w;
    logic [SIZE_W-1:0]        remain_w;

    lldma_regs #(.REG_AW(REG_AW), .CHAN_IDX(CHAN_IDX), .SIZE_W(SIZE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_w),
        .listing(listing_w), .moving(moving_w), .remain(remain_w),
        .fill_we(fill_we_w), .fill_idx(fill_idx_w), .fill_data(fill_data_w),
        .start_req(start_w), .cancel_req(cancel_w), .cfg_rd_addr(mv_rd_addr),
        .cfg_wr_addr(mv_wr_addr), .cfg_size(mv_size), .cfg_node(node_w)
    );

    lldma_seq #(.MEM_AW(MEM_AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_w), .cancel_req(cancel_w),
        .node_ptr(node_w[MEM_AW-1:0]), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fill_we(fill_we_w), .fill_idx(fill_idx_w), .fill_data(fill_data_w),
        .mv_start(mv_start), .mv_abort(mv_abort), .mv_done(mv_done), .evt(evt),
        .busy(busy_w), .listing(listing_w), .moving(moving_w), .go_idle(go_idle_w)
    );

    lldma_remain #(.SIZE_W(SIZE_W), .BYTE_W(BYTE_W)) u_remain (
        .clk(clk), .rst_n(rst_n), .clear(go_idle_w), .load(mv_start),
        .load_val(mv_size), .beat(mv_beat), .bytes(mv_bytes), .remain(remain_w)
    );
endmodule

// File: rtl/lldma_checker.sv
// Protocol and state checks for the loader, bound to its top.
// Assumes the memory never grants and returns data in the same cycle.
module lldma_checker #(
    parameter int MEM_AW = 32,
    parameter int SIZE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mv_start,
    input logic              mv_abort,
    input logic              mv_done,
    input logic              evt,
    input logic              busy,
    input logic              moving,
    input logic              cancel,
    input logic [SIZE_W-1:0] remain
);
    logic outstanding;

    // Tracks a granted read whose data has not yet returned.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outstanding <= 1'b0;
        else if (mem_req && mem_gnt)
            outstanding <= 1'b1;
        else if (mem_rvalid)
            outstanding <= 1'b0;
    end

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !cancel) |=> (mem_req && $stable(mem_addr)));

    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outstanding);

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start);

    p_evt_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && mv_done && !cancel) |-> evt);

    p_no_req_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_abort_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mv_abort |=> !busy);

    p_remain_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (remain == {SIZE_W{1'b1}}));
endmodule

bind lldma_loader lldma_checker #(.MEM_AW(MEM_AW), .SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_addr(mem_addr), .mv_start(mv_start),
    .mv_abort(mv_abort), .mv_done(mv_done), .evt(evt), .busy(busy_w),
    .moving(moving_w), .cancel(cancel_w), .remain(remain_w)
);

// File: tb/lldma_loader_bench.sv
`timescale 1ns/1ps
// Directed bench: memory model, mover model and one task per scenario.
module lldma_loader_bench;
    localparam int BASE  = 2 * 64;
    localparam int OTHER = 1 * 64;

    logic        clk = 0, rst_n = 0, reg_we = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        mem_req, mem_gnt = 0, mem_rvalid = 0;
    logic [31:0] mem_addr, mem_rdata = 0;
    logic        mv_start, mv_abort, evt;
    logic [31:0] mv_rd_addr, mv_wr_addr;
    logic [23:0] mv_size;
    logic        mv_beat = 0, mv_done = 0;
    logic [3:0]  mv_bytes = 0;

    lldma_loader u_lldma_loader (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mv_start(mv_start), .mv_abort(mv_abort),
        .mv_rd_addr(mv_rd_addr), .mv_wr_addr(mv_wr_addr), .mv_size(mv_size),
        .mv_beat(mv_beat), .mv_bytes(mv_bytes), .mv_done(mv_done), .evt(evt)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    int evt_cnt = 0, start_cnt = 0, abort_cnt = 0, fetch_cnt = 0;
    logic [31:0] fa [64];
    logic [31:0] st_rd [16];
    logic [31:0] st_wr [16];
    logic [23:0] st_sz [16];
    logic [31:0] mem [256];
    logic        pend = 0;
    logic [7:0]  paddr = 0;
    int served = 0, abort_seen = 0, mrem = 0, beat_count = 0;
    int beat_limit = 1000000;
    logic act = 0;
    bit finished = 0;

    // Monitor: counts strobes and records fetch and start data at the edge.
    always @(posedge clk) begin
        if (rst_n) begin
            if (evt) evt_cnt <= evt_cnt + 1;
            if (mv_abort) abort_cnt <= abort_cnt + 1;
            if (mem_req && mem_gnt) begin
                fa[fetch_cnt % 64] <= mem_addr;
                fetch_cnt <= fetch_cnt + 1;
            end
            if (mv_start) begin
                st_rd[start_cnt % 16] <= mv_rd_addr;
                st_wr[start_cnt % 16] <= mv_wr_addr;
                st_sz[start_cnt % 16] <= mv_size;
                start_cnt <= start_cnt + 1;
            end
        end
    end

    // Memory model: grant one request, return its word on the next cycle.
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        mem_gnt    <= 1'b0;
        if (pend) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[paddr];
            pend       <= 1'b0;
        end else if (mem_req && !mem_gnt) begin
            mem_gnt <= 1'b1;
            paddr   <= mem_addr[9:2];
            pend    <= 1'b1;
        end
    end

    // Mover model: moves up to 4 bytes a beat, gated by beat_limit.
    always @(negedge clk) begin
        mv_beat <= 1'b0;
        mv_done <= 1'b0;
        if (abort_cnt != abort_seen) begin
            abort_seen <= abort_cnt;
            act        <= 1'b0;
        end else if (start_cnt != served) begin
            served <= served + 1;
            act    <= 1'b1;
            mrem   <= int'(st_sz[served % 16]) + 1;
        end else if (act && beat_count < beat_limit) begin
            beat_count <= beat_count + 1;
            if (mrem == 0) begin
                mv_done <= 1'b1;
                act     <= 1'b0;
            end else begin
                mv_beat  <= 1'b1;
                mv_bytes <= 4'((mrem > 4) ? 4 : mrem);
                mrem     <= mrem - ((mrem > 4) ? 4 : mrem);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = 12'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 12'(a);
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input int a, input logic [31:0] gen, input logic [31:0] rda,
                            input logic [31:0] wra, input logic [31:0] sz, input logic [31:0] nxt);
        mem[a/4 + 0] = gen;
        mem[a/4 + 1] = 32'h0000_0042;
        mem[a/4 + 2] = rda;
        mem[a/4 + 3] = wra;
        mem[a/4 + 4] = sz;
        mem[a/4 + 5] = nxt;
        mem[a/4 + 6] = 32'h0;
        mem[a/4 + 7] = 32'h0000_0011;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(BASE + 'h1C, v);
            if (v == 0) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(BASE + 'h1C, v);  check("R2 ctrl after reset", v, 32'h0);
        rd(BASE + 'h30, v);  check("R9 remain after reset", v, 32'h00FF_FFFF);
        check("R6 no request after reset", 32'(mem_req), 32'h0);
        check("R5 no event after reset", 32'(evt_cnt), 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        int e0 = evt_cnt, s0 = start_cnt, f0 = fetch_cnt;
        put_desc('h100, 32'hA000_0088, 32'h1000, 32'h2000, 32'd9, 32'h0);
        wr(BASE + 'h14, 32'h100);
        wr(BASE + 'h1C, 32'h10);
        rd(BASE + 'h1C, v);  check("R2 list bit set after start", 32'(v[4]), 32'h1);
        wait_idle();
        check("R5 events for one node", 32'(evt_cnt - e0), 32'd2);
        check("R4 one start", 32'(start_cnt - s0), 32'd1);
        check("R4 start read addr", st_rd[s0 % 16], 32'h1000);
        check("R4 start write addr", st_wr[s0 % 16], 32'h2000);
        check("R4 start size", 32'(st_sz[s0 % 16]), 32'd9);
        check("R3 eight fetches", 32'(fetch_cnt - f0), 32'd8);
        check("R3 first fetch addr", fa[f0 % 64], 32'h100);
        check("R3 last fetch addr", fa[(f0 + 7) % 64], 32'h11C);
        rd(BASE + 'h00, v);  check("R3 word 0 in window", v, 32'hA000_0088);
        rd(BASE + 'h10, v);  check("R1 size slot", v, 32'd9);
        rd(BASE + 'h1C, v);  check("R6 ctrl clear at list end", v, 32'h0);
        rd(BASE + 'h30, v);  check("R9 remain all ones at end", v, 32'h00FF_FFFF);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        int e0 = evt_cnt, s0 = start_cnt, f0 = fetch_cnt;
        put_desc('h140, 32'h1, 32'h1100, 32'h2100, 32'd3, 32'h180);
        put_desc('h180, 32'h2, 32'h1200, 32'h2200, 32'd5, 32'h1C0);
        put_desc('h1C0, 32'h3, 32'h1300, 32'h2300, 32'd7, 32'h0);
        wr(BASE + 'h14, 32'h140);
        wr(BASE + 'h1C, 32'h10);
        wait_idle();
        check("R5 events for three nodes", 32'(evt_cnt - e0), 32'd4);
        check("R6 three starts", 32'(start_cnt - s0), 32'd3);
        check("R6 second command", st_rd[(s0 + 1) % 16], 32'h1200);
        check("R6 third command", st_rd[(s0 + 2) % 16], 32'h1300);
        check("R6 third size", 32'(st_sz[(s0 + 2) % 16]), 32'd7);
        check("R6 24 fetches", 32'(fetch_cnt - f0), 32'd24);
        check("R6 follows pointer", fa[(f0 + 8) % 64], 32'h180);
        rd(BASE + 'h14, v);  check("R3 last node pointer loaded", v, 32'h0);
    endtask

    task automatic t_remain();
        logic [31:0] v;
        int e0 = evt_cnt, s0 = start_cnt;
        put_desc('h280, 32'h5, 32'h1400, 32'h2400, 32'd19, 32'h0);
        beat_limit = beat_count;
        wr(BASE + 'h14, 32'h280);
        wr(BASE + 'h1C, 32'h10);
        for (int i = 0; i < 300 && start_cnt == s0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        rd(BASE + 'h30, v);  check("R9 remain loaded with size", v, 32'd19);
        rd(BASE + 'h1C, v);  check("R2 list and run bits while moving", v, 32'h11);
        wr(BASE + 'h08, 32'hDEAD_BEEF);
        rd(BASE + 'h08, v);  check("R10 write ignored while busy", v, 32'h1400);
        beat_limit = beat_count + 2;
        repeat (6) @(negedge clk);
        rd(BASE + 'h30, v);  check("R9 remain after two beats", v, 32'd11);
        beat_limit = 1000000;
        wait_idle();
        rd(BASE + 'h30, v);  check("R9 remain wraps to all ones", v, 32'h00FF_FFFF);
        check("R5 events after remain test", 32'(evt_cnt - e0), 32'd2);
    endtask

    task automatic t_cyclic();
        logic [31:0] v;
        int e0 = evt_cnt, s0 = start_cnt, a0 = abort_cnt, f1, s1, e1;
        put_desc('h300, 32'h6, 32'h3000, 32'h5000, 32'd15, 32'h340);
        put_desc('h340, 32'h7, 32'h4000, 32'h6000, 32'd15, 32'h300);
        wr(BASE + 'h14, 32'h300);
        wr(BASE + 'h1C, 32'h10);
        for (int i = 0; i < 5000 && (start_cnt - s0) < 5; i++) @(negedge clk);
        beat_limit = beat_count;
        repeat (3) @(negedge clk);
        check("R7 loop keeps issuing", 32'(start_cnt - s0), 32'd5);
        check("R7 events in loop", 32'(evt_cnt - e0), 32'd5);
        check("R7 loop order 2", st_rd[(s0 + 1) % 16], 32'h4000);
        check("R7 loop back to head", st_rd[(s0 + 2) % 16], 32'h3000);
        check("R7 loop order 4", st_rd[(s0 + 3) % 16], 32'h4000);
        wr(BASE + 'h1C, 32'h0010_0000);
        check("R8 abort pulse", 32'(abort_cnt - a0), 32'd1);
        rd(BASE + 'h1C, v);  check("R8 ctrl clear after cancel", v, 32'h0);
        rd(BASE + 'h30, v);  check("R8 remain reset by cancel", v, 32'h00FF_FFFF);
        f1 = fetch_cnt; s1 = start_cnt; e1 = evt_cnt;
        repeat (30) @(negedge clk);
        check("R8 no fetch after cancel", 32'(fetch_cnt - f1), 32'd0);
        check("R8 no start after cancel", 32'(start_cnt - s1), 32'd0);
        check("R8 no event after cancel", 32'(evt_cnt - e1), 32'd0);
        beat_limit = 1000000;
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        int f0 = fetch_cnt;
        wr(BASE + 'h1C, 32'h0010_0000);
        rd(BASE + 'h1C, v);  check("R8 cancel while idle", v, 32'h0);
        wr(BASE + 'h14, 32'h100);
        wr(BASE + 'h1C, 32'h0010_0010);
        rd(BASE + 'h1C, v);  check("R2 both bits do not start", v, 32'h0);
        wr(OTHER + 'h14, 32'h100);
        wr(OTHER + 'h1C, 32'h10);
        repeat (10) @(negedge clk);
        check("R1 other window no start", 32'(fetch_cnt - f0), 32'd0);
        rd(OTHER + 'h14, v); check("R1 other window reads zero", v, 32'h0);
        wr(BASE + 'h0C, 32'h1234_5678);
        rd(BASE + 'h0C, v);  check("R1 idle slot write", v, 32'h1234_5678);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_single();
        t_chain();
        t_remain();
        t_cyclic();
        t_ignored();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule